// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This block decides when the core of a small 8-bit microcontroller may sleep and what brings it back. Software issues one control write carrying two request bits, a light-sleep (idle) request and a deep-sleep (power-down) request. In idle the block drops only the CPU clock enable. Peripheral clocks keep running, so CPU state and port levels stay frozen in place. In power-down it also drops the oscillator enable and raises a flash power-down output. Only a narrow set of sources may end power-down.

Idle ends on any enabled interrupt request while the global interrupt enable is set. In power-down the interrupt flag logic has no clock, so the pending flags of the external lines cannot be trusted. Those lines are therefore judged from their pins, through a synchronizer on the always-on clock the block runs from. The trigger kind chosen for each line decides whether a pin state or a pin transition counts. After every reset and after every exit from power-down, a hold-off counter refuses new power-down requests for a parameter number of cycles. Both request bits clear by hardware on wake-up, because the state returns to running.

All pins are plain control and status signals. Nothing streams through the block, so it has no valid/ready interface and applies no back-pressure.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, the block is running: cpu_clk_en=1, osc_en=1, flash_pd=0, idle_mode=0, pd_mode=0, wake_pulse=0. Asserting rst_n ends either low-power mode immediately.
- R2: In the running state, a ctl_wr with ctl_idle_set=1 and ctl_pd_set=0 makes idle_mode=1 and cpu_clk_en=0 from the next cycle, while osc_en stays 1 and flash_pd stays 0.
- R3: Idle returns to running at the next clock edge when glb_irq_en=1 and at least one of these is 1: ext_en[i]&ext_pend[i] for any line, kbd_en&kbd_pend, usb_en&usb_pend, or periph_irq. With glb_irq_en=0 the block stays idle.
- R4: Every exit from a low-power mode raises wake_pulse for exactly one cycle, the first cycle in which cpu_clk_en is 1 again.
- R5: A hold-off counter is loaded with HOLD_CYC on reset and counts down once per cycle. While it is nonzero, the power-down bit of a write is ignored. If the same write also carries the idle bit, the block enters idle instead.
- R6: A power-down write accepted in the running state gives pd_mode=1, osc_en=0, flash_pd=1 and cpu_clk_en=0 from the next cycle.
- R7: In power-down, ext_pend and periph_irq have no effect. With glb_irq_en=1, kbd_en&kbd_pend or usb_en&usb_pend ends power-down at the next edge.
- R8: External pins pass through a two-stage synchronizer. In power-down, line i wakes the core when glb_irq_en=1, ext_en[i]=1 and its synchronized pin matches its trigger. ext_trig_edge[i]=0 means level and 1 means edge. ext_trig_pol[i]=0 means low or falling and 1 means high or rising. Lines 2 and 3 accept all four settings. A pin change made after one clock edge ends power-down at the third edge after it.
- R9: Lines 0 and 1 never end power-down when ext_trig_pol is 1 (high level or rising edge), whatever their pins do.
- R10: When one write sets both request bits and the hold-off has expired, power-down wins over idle.
- R11: Each exit from power-down reloads the hold-off counter with HOLD_CYC, so a power-down write in the cycles right after the wake is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset (any reset source) |
| ctl_wr | input | 1 | Control write strobe |
| ctl_idle_set | input | 1 | Idle request bit of the write |
| ctl_pd_set | input | 1 | Power-down request bit of the write |
| glb_irq_en | input | 1 | Global interrupt enable |
| ext_en | input | 4 | Per-line external interrupt enable |
| ext_pend | input | 4 | Per-line external interrupt pending flag |
| ext_trig_edge | input | 4 | Trigger kind per line: 0 level, 1 edge |
| ext_trig_pol | input | 4 | Trigger polarity per line: 0 low/falling, 1 high/rising |
| ext_pin | input | 4 | Raw external interrupt pins |
| kbd_en | input | 1 | Keypad interrupt enable |
| kbd_pend | input | 1 | Keypad interrupt pending |
| usb_en | input | 1 | USB interrupt enable |
| usb_pend | input | 1 | USB interrupt pending |
| periph_irq | input | 1 | Other enabled peripheral requests (idle only) |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| flash_pd | output | 1 | Flash power-down |
| idle_mode | output | 1 | Idle state indicator |
| pd_mode | output | 1 | Power-down state indicator |
| wake_pulse | output | 1 | One-cycle pulse on wake-up |

## Verification
The bench first tries power-down right after reset and right after a wake. A design that ignores or forgets to reload the hold-off would fall straight back asleep. In power-down it holds pending flags and timer-class requests high; a design that reused the idle wake logic would wake on them. It drives lines 0 and 1 high and with rising edges while they are configured for high or rising triggers. It also runs a rising edge on line 2 and a both-bits write. A design that misapplies the restriction, drops edges or counts synchronizer stages wrongly shows a wrong or mistimed wake.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_state_e;
endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] pin_cur,
  output logic [W-1:0] pin_prv
);
  logic [W-1:0] chain [STAGES];

  // Idle pin level is high; reset the chain there.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= pin_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign pin_cur = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prv <= '1;
    else        pin_prv <= pin_cur;
  end
endmodule

// File: rtl/pwr_wake_eval.sv
module pwr_wake_eval #(
  parameter int N_EXT     = 4,
  parameter int N_LOWONLY = 2
) (
  input  logic             glb_irq_en,
  input  logic [N_EXT-1:0] ext_en,
  input  logic [N_EXT-1:0] ext_pend,
  input  logic [N_EXT-1:0] ext_trig_edge,
  input  logic [N_EXT-1:0] ext_trig_pol,
  input  logic [N_EXT-1:0] pin_cur,
  input  logic [N_EXT-1:0] pin_prv,
  input  logic             kbd_en,
  input  logic             kbd_pend,
  input  logic             usb_en,
  input  logic             usb_pend,
  input  logic             periph_irq,
  output logic             idle_wake,
  output logic             pd_wake
);
  logic [N_EXT-1:0] line_pd;
  logic             side_req;

  generate
    for (genvar i = 0; i < N_EXT; i++) begin : g_line
      logic hit_lvl, hit_edge, hit;
      assign hit_lvl  = ext_trig_pol[i] ? pin_cur[i] : ~pin_cur[i];
      assign hit_edge = ext_trig_pol[i] ? (pin_cur[i] & ~pin_prv[i])
                                        : (~pin_cur[i] & pin_prv[i]);
      assign hit      = ext_trig_edge[i] ? hit_edge : hit_lvl;
      if (i < N_LOWONLY) begin : g_restricted
        // Only low level or falling edge may end deep sleep here.
        assign line_pd[i] = ext_en[i] & ~ext_trig_pol[i] & hit;
      end else begin : g_full
        assign line_pd[i] = ext_en[i] & hit;
      end
    end
  endgenerate

  assign side_req  = (kbd_en & kbd_pend) | (usb_en & usb_pend);
  assign idle_wake = glb_irq_en & ((|(ext_en & ext_pend)) | side_req | periph_irq);
  assign pd_wake   = glb_irq_en & ((|line_pd) | side_req);
endmodule

// File: rtl/pwr_holdoff.sv
module pwr_holdoff #(
  parameter int HOLD_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic busy
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= LOAD;
    else if (reload)     cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  generate
    if (HOLD_CYC > 0) begin : g_chk
      p_reload_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> busy)
        else $error("hold-off not busy after reload");
    end
  endgenerate
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int N_EXT       = 4,
  parameter int N_LOWONLY   = 2,
  parameter int HOLD_CYC    = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_idle_set,
  input  logic             ctl_pd_set,
  input  logic             glb_irq_en,
  input  logic [N_EXT-1:0] ext_en,
  input  logic [N_EXT-1:0] ext_pend,
  input  logic [N_EXT-1:0] ext_trig_edge,
  input  logic [N_EXT-1:0] ext_trig_pol,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic             kbd_en,
  input  logic             kbd_pend,
  input  logic             usb_en,
  input  logic             usb_pend,
  input  logic             periph_irq,
  output logic             cpu_clk_en,
  output logic             osc_en,
  output logic             flash_pd,
  output logic             idle_mode,
  output logic             pd_mode,
  output logic             wake_pulse
);
  pm_state_e        st, st_nxt;
  logic [N_EXT-1:0] pin_cur, pin_prv;
  logic             idle_wake, pd_wake, hold_busy, pd_exit, wake_nxt;

  pwr_pin_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_raw(ext_pin),
    .pin_cur(pin_cur), .pin_prv(pin_prv)
  );

  pwr_wake_eval #(.N_EXT(N_EXT), .N_LOWONLY(N_LOWONLY)) u_eval (
    .glb_irq_en(glb_irq_en), .ext_en(ext_en), .ext_pend(ext_pend),
    .ext_trig_edge(ext_trig_edge), .ext_trig_pol(ext_trig_pol),
    .pin_cur(pin_cur), .pin_prv(pin_prv),
    .kbd_en(kbd_en), .kbd_pend(kbd_pend), .usb_en(usb_en), .usb_pend(usb_pend),
    .periph_irq(periph_irq), .idle_wake(idle_wake), .pd_wake(pd_wake)
  );

  assign pd_exit = (st == PM_DOWN) && pd_wake;

  pwr_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .reload(pd_exit), .busy(hold_busy)
  );

  always_comb begin
    st_nxt   = st;
    wake_nxt = 1'b0;
    unique case (st)
      PM_RUN: begin
        if (ctl_wr) begin
          if (ctl_pd_set && !hold_busy) st_nxt = PM_DOWN;
          else if (ctl_idle_set)        st_nxt = PM_IDLE;
        end
      end
      PM_IDLE: begin
        if (idle_wake) begin
          st_nxt   = PM_RUN;
          wake_nxt = 1'b1;
        end
      end
      PM_DOWN: begin
        if (pd_wake) begin
          st_nxt   = PM_RUN;
          wake_nxt = 1'b1;
        end
      end
      default: st_nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= PM_RUN;
      wake_pulse <= 1'b0;
    end else begin
      st         <= st_nxt;
      wake_pulse <= wake_nxt;
    end
  end

  assign cpu_clk_en = (st == PM_RUN);
  assign osc_en     = (st != PM_DOWN);
  assign flash_pd   = (st == PM_DOWN);
  assign idle_mode  = (st == PM_IDLE);
  assign pd_mode    = (st == PM_DOWN);

  p_one_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idle_mode, pd_mode}))
    else $error("two modes at once");

  p_holdoff_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && ctl_wr && ctl_pd_set && hold_busy) |=> !pd_mode)
    else $error("power-down entered during hold-off");

  p_wake_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (cpu_clk_en && $past(!cpu_clk_en)))
    else $error("wake pulse not on first running cycle");

  p_pd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode && !pd_wake) |=> pd_mode)
    else $error("left power-down without a qualified source");

  p_exit_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_mode) |-> hold_busy)
    else $error("hold-off not reloaded on exit");

  p_pd_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_mode) |-> $past(ctl_wr && ctl_pd_set))
    else $error("power-down without a request");
endmodule

// File: tb/tb_pwr_wake_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_wake_ctrl;
  localparam int HOLD = 500;

  logic clk = 0;
  logic rst_n = 0;
  logic ctl_wr = 0, ctl_idle_set = 0, ctl_pd_set = 0, glb_irq_en = 0;
  logic [3:0] ext_en = 0, ext_pend = 0, ext_trig_edge = 0, ext_trig_pol = 0;
  logic [3:0] ext_pin = 4'hF;
  logic kbd_en = 0, kbd_pend = 0, usb_en = 0, usb_pend = 0, periph_irq = 0;
  logic cpu_clk_en, osc_en, flash_pd, idle_mode, pd_mode, wake_pulse;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  pwr_wake_ctrl dut (.*);

  // Behavioural reference: state 0 run, 1 idle, 2 power-down.
  int m_st, m_cnt;
  logic m_wk;
  logic [3:0] m_d1, m_d2, m_d3;

  function automatic logic ref_pd_wake();
    logic w;
    w = (kbd_en & kbd_pend) | (usb_en & usb_pend);
    for (int i = 0; i < 4; i++) begin
      logic hit;
      if (ext_trig_edge[i])
        hit = ext_trig_pol[i] ? (m_d2[i] & ~m_d3[i]) : (~m_d2[i] & m_d3[i]);
      else
        hit = ext_trig_pol[i] ? m_d2[i] : ~m_d2[i];
      if (ext_en[i] && hit && !(i < 2 && ext_trig_pol[i])) w = 1;
    end
    return glb_irq_en & w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = HOLD; m_wk = 0; m_d1 = '1; m_d2 = '1; m_d3 = '1;
    end else begin
      logic pdw, idw;
      int nst, ncnt;
      logic nwk;
      pdw = ref_pd_wake();
      idw = glb_irq_en & ((|(ext_en & ext_pend)) | (kbd_en & kbd_pend) |
                          (usb_en & usb_pend) | periph_irq);
      nst = m_st; nwk = 0; ncnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      if (m_st == 0 && ctl_wr) begin
        if (ctl_pd_set && m_cnt == 0) nst = 2;
        else if (ctl_idle_set) nst = 1;
      end else if (m_st == 1 && idw) begin
        nst = 0; nwk = 1;
      end else if (m_st == 2 && pdw) begin
        nst = 0; nwk = 1; ncnt = HOLD;
      end
      m_st = nst; m_wk = nwk; m_cnt = ncnt;
      m_d3 = m_d2; m_d2 = m_d1; m_d1 = ext_pin;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(cur_req, "cpu_clk_en", cpu_clk_en, m_st == 0);
    chk(cur_req, "osc_en", osc_en, m_st != 2);
    chk(cur_req, "flash_pd", flash_pd, m_st == 2);
    chk(cur_req, "idle_mode", idle_mode, m_st == 1);
    chk(cur_req, "pd_mode", pd_mode, m_st == 2);
    chk(cur_req, "wake_pulse", wake_pulse, m_wk);
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic idl, logic pd);
    ctl_wr = 1; ctl_idle_set = idl; ctl_pd_set = pd;
    tick();
    ctl_wr = 0; ctl_idle_set = 0; ctl_pd_set = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cur_req = "R1";
    tick(3);
    chk("R1", "reset cpu_clk_en", cpu_clk_en, 1'b1);
    chk("R1", "reset osc_en", osc_en, 1'b1);
    rst_n = 1;
    tick(2);
    chk("R1", "after reset pd_mode", pd_mode, 1'b0);

    // Early power-down write refused; both bits during hold-off gives idle.
    cur_req = "R5";
    wr(0, 1);
    chk("R5", "refused pd_mode", pd_mode, 1'b0);
    wr(1, 1);
    chk("R5", "idle instead idle_mode", idle_mode, 1'b1);

    cur_req = "R3";
    glb_irq_en = 1; kbd_en = 1; kbd_pend = 1;
    tick();
    chk("R3", "kbd woke idle cpu_clk_en", cpu_clk_en, 1'b1);
    chk("R4", "wake_pulse after idle", wake_pulse, 1'b1);
    kbd_pend = 0;
    tick();
    chk("R4", "wake_pulse one cycle", wake_pulse, 1'b0);

    cur_req = "R2";
    glb_irq_en = 0; usb_en = 1; usb_pend = 1;
    wr(1, 0);
    chk("R2", "idle osc_en", osc_en, 1'b1);
    chk("R2", "idle cpu_clk_en", cpu_clk_en, 1'b0);
    cur_req = "R3";
    tick(5);
    chk("R3", "no global enable stays idle", idle_mode, 1'b1);
    usb_pend = 0; glb_irq_en = 1; periph_irq = 1;
    tick();
    chk("R3", "periph_irq woke idle", idle_mode, 1'b0);
    periph_irq = 0;

    // Reset ends idle.
    cur_req = "R1";
    wr(1, 0);
    rst_n = 0;
    tick();
    chk("R1", "reset ends idle", idle_mode, 1'b0);
    rst_n = 1;
    tick(HOLD + 10);

    // Power-down ignores pending flags and peripheral requests.
    cur_req = "R6";
    ext_trig_edge = 4'hF; ext_trig_pol = 4'h0;
    wr(0, 1);
    chk("R6", "pd osc_en", osc_en, 1'b0);
    chk("R6", "pd flash_pd", flash_pd, 1'b1);
    cur_req = "R7";
    ext_en = 4'hF; ext_pend = 4'hF; periph_irq = 1;
    tick(10);
    chk("R7", "pend/periph ignored pd_mode", pd_mode, 1'b1);
    usb_pend = 1;
    tick();
    chk("R7", "usb woke pd", pd_mode, 1'b0);
    usb_pend = 0; ext_en = 0; ext_pend = 0; periph_irq = 0;
    cur_req = "R11";
    wr(0, 1);
    chk("R11", "re-entry refused", pd_mode, 1'b0);
    tick(HOLD + 10);

    // Lines 0 and 1 with high/rising settings never wake power-down.
    cur_req = "R9";
    ext_trig_edge = 4'b0010; ext_trig_pol = 4'b0011; ext_en = 4'b0011;
    ext_pin = 4'hC;
    tick(4);
    wr(0, 1);
    ext_pin = 4'hF;
    tick(4);
    ext_pin = 4'hD; tick(2); ext_pin = 4'hF;
    tick(6);
    chk("R9", "restricted lines no wake", pd_mode, 1'b1);
    // Line 0 as low level wakes after synchronizer.
    cur_req = "R8";
    ext_trig_pol = 4'b0000; ext_trig_edge = 4'b0000; ext_en = 4'b0001;
    tick(3);
    ext_pin = 4'hE;
    tick(2);
    chk("R8", "low level not yet seen", pd_mode, 1'b1);
    tick();
    chk("R8", "low level wake third edge", pd_mode, 1'b0);
    ext_pin = 4'hF; ext_en = 0;
    tick(HOLD + 10);

    // Line 2 rising edge.
    ext_pin = 4'hB; ext_trig_edge = 4'b0100; ext_trig_pol = 4'b0100;
    tick(4);
    ext_en = 4'b0100;
    wr(0, 1);
    tick(5);
    chk("R8", "line2 idle low no wake", pd_mode, 1'b1);
    ext_pin = 4'hF;
    tick(3);
    chk("R8", "line2 rising wake", pd_mode, 1'b0);
    ext_en = 0;
    tick(HOLD + 10);

    cur_req = "R10";
    wr(1, 1);
    chk("R10", "pd wins pd_mode", pd_mode, 1'b1);
    chk("R10", "pd wins idle_mode", idle_mode, 1'b0);
    kbd_pend = 1;
    tick();
    chk("R10", "kbd woke pd", pd_mode, 1'b0);
    kbd_pend = 0;
    tick(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule